// File: doc/BRIEF.md
# Transmit Link Synchronization Sequencer

This block sits on the transmit side of a multi-lane serial converter link and decides, for every octet slot, what each lane sends: the comma character that lets the receivers lock their code-group boundaries, a four-multiframe lane alignment sequence, or the user's payload. Its per-lane output is an octet plus a control flag, ready for a downstream 8b/10b encoder. The encoder, serializer, scrambler and the generation of the frame and multiframe timing strobes live elsewhere.

Receivers request synchronization by pulling active-low request lines. These lines are merged, and the comma phase ends only once every one of them is high. The block then waits for the first frame boundary (subclass 0) or the first multiframe boundary (subclasses 1, 2 and 3) and switches on exactly that octet, to alignment if enabled or straight to data if not. A request held low for a full frame later on drops the link back into the comma phase.

All outputs come from registers. The boundary strobes mean "the octet loaded at this clock edge starts a frame / multiframe". User data is registered once, so a lane's data octet appears one cycle after it is presented.

Top module: `lane_sync_tx`

## Requirements
- R1: After reset the block is in the comma phase: `state_o` reads 0 (0 = comma, 1 = alignment, 2 = data) and every lane sends 0xBC with its control flag high.
- R2: While any bit of `sync_n_i` is low in the comma phase, every lane keeps sending 0xBC with the control flag high and `state_o` stays 0.
- R3: The request lines are combined: the comma phase persists while at least one of them is still low, even if the others have been released.
- R4: With `subclass_i` = 0 and all requests high, the first octet loaded on an edge where `frame_bnd_i` is high is new content; all octets before it are commas.
- R5: With `subclass_i` nonzero and all requests high, frame strobes do not end the comma phase; the first edge with `mf_bnd_i` high loads the first new octet, never a later one.
- R6: With `ilas_en_i` low, the octet at the release boundary is already user data (`state_o` = 2), with no alignment sequence.
- R7: With `ilas_en_i` high, the alignment sequence spans four multiframes of FRAME_OCTETS*FRAMES_PER_MF octets. At position p of multiframe m: p = last is 0x7C control; p = 0 is 0x1C control; in m = 1, p = 1 is 0x9C control and p = 2..5 are data octets LANES-1, FRAME_OCTETS-1, FRAMES_PER_MF-1 and the lane index; every other octet is data with value p.
- R8: User data starts on the octet after the last alignment octet; during data each lane outputs the octet presented one cycle earlier, control flag low.
- R9: Outside the comma phase, a request low for FRAME_OCTETS consecutive cycles returns the block to the comma phase on the next octet; a shorter low pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Octet clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_n_i | input | SYNC_W | Synchronization requests, active low, one per receiver |
| frame_bnd_i | input | 1 | Octet loaded at this edge begins a frame |
| mf_bnd_i | input | 1 | Octet loaded at this edge begins a multiframe |
| subclass_i | input | 2 | Link subclass; 0 releases on frame, others on multiframe |
| ilas_en_i | input | 1 | Insert the alignment sequence after the comma phase |
| data_i | input | LANES*8 | User octets, lane 0 in the low byte |
| char_o | output | LANES*8 | Octet per lane to the encoder, lane 0 in the low byte |
| ctrl_o | output | LANES | Control-character flag per lane |
| state_o | output | 2 | 0 comma, 1 alignment, 2 data |

## Verification
The hardest situation to reach is the release landing between boundaries: the requests must go high at a chosen phase of the frame and multiframe counters so that several frame strobes pass before the multiframe strobe in subclass 1, and so that the frame strobe comes a few octets later in subclass 0. The bench drives the strobes from its own octet counter and releases the requests only when that counter reaches a chosen residue, so the exact number of trailing commas is known in advance. Resynchronization is reached from the data phase by holding a request low one cycle short of a frame and then for exactly a frame.

// File: rtl/lane_sync_pkg.sv
package lane_sync_pkg;
  typedef enum logic [1:0] {
    ST_CGS  = 2'd0,
    ST_ILAS = 2'd1,
    ST_DATA = 2'd2
  } tx_state_e;

  localparam logic [7:0] K_COMMA = 8'hBC;
  localparam logic [7:0] K_MF_START = 8'h1C;
  localparam logic [7:0] K_MF_END = 8'h7C;
  localparam logic [7:0] K_CFG_START = 8'h9C;
  localparam int unsigned ILAS_MFS = 4;
endpackage

// File: rtl/link_sync_fsm.sv
module link_sync_fsm
  import lane_sync_pkg::*;
#(
  parameter int unsigned FRAME_OCTETS  = 4,
  parameter int unsigned FRAMES_PER_MF = 4,
  parameter int unsigned SYNC_W        = 2,
  localparam int unsigned MF_OCTETS = FRAME_OCTETS * FRAMES_PER_MF,
  localparam int unsigned PW = $clog2(MF_OCTETS),
  localparam int unsigned LW = $clog2(FRAME_OCTETS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SYNC_W-1:0] sync_n_i,
  input  logic              frame_bnd_i,
  input  logic              mf_bnd_i,
  input  logic [1:0]        subclass_i,
  input  logic              ilas_en_i,
  output tx_state_e         state_o,
  output logic [PW-1:0]     pos_o,
  output logic [1:0]        mfc_o
);
  tx_state_e     st_q;
  logic [PW-1:0] pos_q;
  logic [1:0]    mfc_q;
  logic [LW-1:0] lo_q;

  logic all_rel, rel_hit, resync, pos_last;

  assign all_rel  = &sync_n_i;
  assign rel_hit  = all_rel && ((subclass_i == 2'd0) ? frame_bnd_i : mf_bnd_i);
  assign resync   = !all_rel && (lo_q == LW'(FRAME_OCTETS - 1));
  assign pos_last = (pos_q == PW'(MF_OCTETS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_CGS;
      pos_q <= '0;
      mfc_q <= '0;
      lo_q  <= '0;
    end else begin
      lo_q <= (st_q != ST_CGS && !all_rel) ? lo_q + 1'b1 : '0;
      unique case (st_q)
        ST_CGS: begin
          if (rel_hit) begin
            st_q  <= ilas_en_i ? ST_ILAS : ST_DATA;
            pos_q <= '0;
            mfc_q <= '0;
          end
        end
        ST_ILAS: begin
          if (resync) begin
            st_q <= ST_CGS;
          end else if (pos_last) begin
            pos_q <= '0;
            mfc_q <= mfc_q + 1'b1;
            if (mfc_q == 2'(ILAS_MFS - 1)) st_q <= ST_DATA;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        ST_DATA: if (resync) st_q <= ST_CGS;
        default: st_q <= ST_CGS;
      endcase
    end
  end

  assign state_o = st_q;
  assign pos_o   = pos_q;
  assign mfc_o   = mfc_q;

  // R2
  hold_comma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CGS && !all_rel) |=> (st_q == ST_CGS));
  // R4
  sc0_frame_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CGS && subclass_i == 2'd0 && !frame_bnd_i) |=> (st_q == ST_CGS));
  // R5
  sc12_mf_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CGS && subclass_i != 2'd0 && !mf_bnd_i) |=> (st_q == ST_CGS));
  // R8
  ilas_full_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ILAS && !(pos_last && mfc_q == 2'(ILAS_MFS - 1))) |=> (st_q != ST_DATA));
  // R9
  no_early_resync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_CGS && all_rel) |=> (st_q != ST_CGS));
endmodule

// File: rtl/ilas_char.sv
module ilas_char
  import lane_sync_pkg::*;
#(
  parameter int unsigned LANES         = 2,
  parameter int unsigned FRAME_OCTETS  = 4,
  parameter int unsigned FRAMES_PER_MF = 4,
  parameter int unsigned LANE_IDX      = 0,
  localparam int unsigned MF_OCTETS = FRAME_OCTETS * FRAMES_PER_MF,
  localparam int unsigned PW = $clog2(MF_OCTETS)
) (
  input  logic [PW-1:0] pos_i,
  input  logic [1:0]    mfc_i,
  output logic [7:0]    char_o,
  output logic          is_k_o
);
  always_comb begin
    char_o = 8'(pos_i);
    is_k_o = 1'b0;
    if (pos_i == PW'(MF_OCTETS - 1)) begin
      char_o = K_MF_END;
      is_k_o = 1'b1;
    end else if (pos_i == '0) begin
      char_o = K_MF_START;
      is_k_o = 1'b1;
    end else if (mfc_i == 2'd1) begin
      unique case (pos_i)
        PW'(1): begin char_o = K_CFG_START; is_k_o = 1'b1; end
        PW'(2): char_o = 8'(LANES - 1);
        PW'(3): char_o = 8'(FRAME_OCTETS - 1);
        PW'(4): char_o = 8'(FRAMES_PER_MF - 1);
        PW'(5): char_o = 8'(LANE_IDX);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lane_sync_tx.sv
module lane_sync_tx
  import lane_sync_pkg::*;
#(
  parameter int unsigned LANES         = 2,
  parameter int unsigned SYNC_W        = 2,
  parameter int unsigned FRAME_OCTETS  = 4,
  parameter int unsigned FRAMES_PER_MF = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SYNC_W-1:0]   sync_n_i,
  input  logic                frame_bnd_i,
  input  logic                mf_bnd_i,
  input  logic [1:0]          subclass_i,
  input  logic                ilas_en_i,
  input  logic [LANES*8-1:0]  data_i,
  output logic [LANES*8-1:0]  char_o,
  output logic [LANES-1:0]    ctrl_o,
  output logic [1:0]          state_o
);
  localparam int unsigned MF_OCTETS = FRAME_OCTETS * FRAMES_PER_MF;
  localparam int unsigned PW = $clog2(MF_OCTETS);

  tx_state_e          st;
  logic [PW-1:0]      pos;
  logic [1:0]         mfc;
  logic [LANES*8-1:0] data_q;

  link_sync_fsm #(
    .FRAME_OCTETS (FRAME_OCTETS),
    .FRAMES_PER_MF(FRAMES_PER_MF),
    .SYNC_W       (SYNC_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_n_i   (sync_n_i),
    .frame_bnd_i(frame_bnd_i),
    .mf_bnd_i   (mf_bnd_i),
    .subclass_i (subclass_i),
    .ilas_en_i  (ilas_en_i),
    .state_o    (st),
    .pos_o      (pos),
    .mfc_o      (mfc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else         data_q <= data_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] ilas_c;
    logic       ilas_k;

    ilas_char #(
      .LANES        (LANES),
      .FRAME_OCTETS (FRAME_OCTETS),
      .FRAMES_PER_MF(FRAMES_PER_MF),
      .LANE_IDX     (l)
    ) u_ilas (
      .pos_i (pos),
      .mfc_i (mfc),
      .char_o(ilas_c),
      .is_k_o(ilas_k)
    );

    always_comb begin
      unique case (st)
        ST_ILAS: begin char_o[l*8 +: 8] = ilas_c; ctrl_o[l] = ilas_k; end
        ST_DATA: begin char_o[l*8 +: 8] = data_q[l*8 +: 8]; ctrl_o[l] = 1'b0; end
        default: begin char_o[l*8 +: 8] = K_COMMA; ctrl_o[l] = 1'b1; end
      endcase
    end
  end

  assign state_o = st;
endmodule

// File: tb/tb_lane_sync_tx.sv
`timescale 1ns/1ps
module tb_lane_sync_tx;
  localparam int LANES = 2;
  localparam int SYNC_W = 2;
  localparam int FO = 4;
  localparam int FPM = 4;
  localparam int MFO = FO * FPM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SYNC_W-1:0] sync_n = '0;
  logic [1:0] subclass = 2'd1;
  logic ilas_en = 1'b1;
  logic [LANES*8-1:0] data;
  logic [LANES*8-1:0] char_o;
  logic [LANES-1:0] ctrl_o;
  logic [1:0] state_o;
  logic frame_bnd, mf_bnd;
  int unsigned tb_cnt = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tb_cnt <= tb_cnt + 1;

  assign frame_bnd = (tb_cnt % FO) == 0;
  assign mf_bnd = (tb_cnt % MFO) == 0;
  for (genvar l = 0; l < LANES; l++) begin : g_d
    assign data[l*8 +: 8] = 8'(tb_cnt) ^ 8'(l * 17);
  end

  lane_sync_tx #(.LANES(LANES), .SYNC_W(SYNC_W), .FRAME_OCTETS(FO), .FRAMES_PER_MF(FPM)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_n_i(sync_n), .frame_bnd_i(frame_bnd),
    .mf_bnd_i(mf_bnd), .subclass_i(subclass), .ilas_en_i(ilas_en), .data_i(data),
    .char_o(char_o), .ctrl_o(ctrl_o), .state_o(state_o)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic chk_comma(input string r);
    chk(r, 32'(state_o), 32'd0);
    for (int l = 0; l < LANES; l++) chk(r, {23'd0, ctrl_o[l], char_o[l*8 +: 8]}, 32'h1BC);
  endtask

  task automatic chk_data(input string r);
    chk(r, 32'(state_o), 32'd2);
    for (int l = 0; l < LANES; l++)
      chk(r, {23'd0, ctrl_o[l], char_o[l*8 +: 8]}, {23'd0, 1'b0, 8'(tb_cnt - 1) ^ 8'(l * 17)});
  endtask

  function automatic logic [8:0] ilas_exp(input int k, input int l);
    int p, m;
    p = k % MFO;
    m = k / MFO;
    if (p == MFO - 1) return {1'b1, 8'h7C};
    if (p == 0) return {1'b1, 8'h1C};
    if (m == 1) begin
      if (p == 1) return {1'b1, 8'h9C};
      if (p == 2) return {1'b0, 8'(LANES - 1)};
      if (p == 3) return {1'b0, 8'(FO - 1)};
      if (p == 4) return {1'b0, 8'(FPM - 1)};
      if (p == 5) return {1'b0, 8'(l)};
    end
    return {1'b0, 8'(p)};
  endfunction

  task automatic wait_phase(input int modv, input int val);
    do @(negedge clk); while ((tb_cnt % modv) != val);
  endtask

  task automatic t_reset;
    chk_comma("R1");
  endtask

  task automatic t_any_low;
    sync_n = 2'b00;
    repeat (20) begin @(negedge clk); chk_comma("R2"); end
    sync_n = 2'b01;
    repeat (20) begin @(negedge clk); chk_comma("R3"); end
    sync_n = 2'b10;
    repeat (20) begin @(negedge clk); chk_comma("R3"); end
  endtask

  task automatic t_sc1_ilas;
    subclass = 2'd1;
    ilas_en = 1'b1;
    wait_phase(MFO, 3);
    sync_n = 2'b11;
    repeat (MFO - 3) begin @(negedge clk); chk_comma("R5"); end
    for (int k = 0; k < 4 * MFO; k++) begin
      @(negedge clk);
      chk("R7", 32'(state_o), 32'd1);
      for (int l = 0; l < LANES; l++)
        chk("R7", {23'd0, ctrl_o[l], char_o[l*8 +: 8]}, {23'd0, ilas_exp(k, l)});
    end
    repeat (6) begin @(negedge clk); chk_data("R8"); end
  endtask

  task automatic t_resync;
    sync_n = 2'b01;
    repeat (FO - 1) begin @(negedge clk); chk_data("R9"); end
    sync_n = 2'b11;
    repeat (3) begin @(negedge clk); chk_data("R9"); end
    sync_n = 2'b10;
    repeat (FO - 1) begin @(negedge clk); chk_data("R9"); end
    @(negedge clk);
    chk_comma("R9");
  endtask

  task automatic t_sc0_skip;
    subclass = 2'd0;
    ilas_en = 1'b0;
    wait_phase(FO, 1);
    sync_n = 2'b11;
    repeat (FO - 1) begin @(negedge clk); chk_comma("R4"); end
    @(negedge clk);
    chk_data("R4");
    repeat (5) begin @(negedge clk); chk_data("R6"); end
  endtask

  task automatic t_sc2_skip;
    sync_n = 2'b00;
    repeat (FO + 1) @(negedge clk);
    chk_comma("R2");
    subclass = 2'd2;
    ilas_en = 1'b0;
    wait_phase(MFO, 5);
    sync_n = 2'b11;
    repeat (MFO - 5) begin @(negedge clk); chk_comma("R5"); end
    @(negedge clk);
    chk_data("R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_any_low();
    t_sc1_ilas();
    t_resync();
    t_sc0_skip();
    t_sc2_skip();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule